// File: doc/BRIEF.md
# Write-Triggered Countdown Wake Timer

This block is a 16-bit countdown timer for low-power wake-up. It has no start or stop bit. Software starts it by writing a non-zero value to the load register and stops it by writing zero there. While the count is non-zero the timer is running. Each tick takes one off the count. When the count steps from one to zero, the block raises a single-cycle wake event and then stays idle at zero.

Ticks come from a 32.768 kHz reference. That reference reaches the block as a one-cycle enable pulse, `lf_tick_i`, in the system clock domain. A resolution bit chooses the tick rate:
- Fine resolution uses every reference pulse, about 30.5 us per count.
- Coarse resolution divides the reference by 4096, which gives 125 ms per count.

The register interface uses three word offsets: load at 0x0, control at 0x4 and a read-only live count at 0x8. Reads are combinational from the address.

Top module: `wake_timer`

## Requirements
- R1: After synchronous reset, the load register, the control register and the count all read 0, and `wake_evt_o` is low.
- R2: A write of a non-zero value V to offset 0x0 sets the count to V at that clock edge. Offset 0x0 then reads back V.
- R3: A write of 0 to offset 0x0 sets the count to 0 at that edge and raises no event. Later reference pulses leave the count at 0.
- R4: With control bit 0 clear (fine resolution), each `lf_tick_i` pulse lowers a non-zero count by exactly one at that edge.
- R5: With control bit 0 set (coarse resolution), the count drops by one on every 4096th `lf_tick_i` pulse. The pulses are counted from the last load write or the last resolution change.
- R6: `wake_evt_o` is high for exactly the one cycle after the edge at which a tick takes the count from 1 to 0. At no other time is it high.
- R7: At a count of 0 the timer is idle. Further pulses neither change the count nor raise the event.
- R8: A load write in the same cycle as a tick takes priority: the count takes the written value.
- R9: Offset 0x8 returns the live count and is read-only. Writes to it change nothing.
- R10: A control write that changes bit 0 restarts the coarse divider phase. A control write that repeats the current value of bit 0 leaves the phase untouched.
- R11: Only control bit 0 is stored. Control bits 15:1 read as 0, and any offset other than 0x0, 0x4 and 0x8 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lf_tick_i | input | 1 | One-cycle pulse per 32.768 kHz reference period |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register byte offset for read and write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| wake_evt_o | output | 1 | Single-cycle wake event on expiry |

## Verification
The count, the stored registers and the event are all registered at the edge that samples the write or tick. They are therefore due one edge after the stimulus, and `rdata_o` follows combinationally from them. The bench drives each stimulus on a falling edge and lets one rising edge pass. At the next falling edge it compares `wake_evt_o` and `rdata_o` with a bench-side model that has taken the same one-edge step.

The coarse tick is due 4096 reference pulses after the phase restarts. The bench reaches it by pulsing the reference every cycle and checking every cycle along the way.

// File: rtl/wt_pkg.sv
package wt_pkg;

    localparam int WT_DATA_W  = 16;
    localparam int WT_ADDR_W  = 4;
    localparam int WT_DIV_LOG = 12;

    localparam logic [WT_ADDR_W-1:0] OFS_LOAD  = 4'h0;
    localparam logic [WT_ADDR_W-1:0] OFS_CTRL  = 4'h4;
    localparam logic [WT_ADDR_W-1:0] OFS_COUNT = 4'h8;

    typedef enum logic [1:0] {
        SEL_LOAD,
        SEL_CTRL,
        SEL_COUNT,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic load;       // load register written this cycle
        logic res_change; // resolution bit toggled by this write
        logic res;        // current resolution: 1 = coarse
    } wt_cmd_t;

    function automatic reg_sel_e decode_ofs(input logic [WT_ADDR_W-1:0] a);
        case (a)
            OFS_LOAD:  return SEL_LOAD;
            OFS_CTRL:  return SEL_CTRL;
            OFS_COUNT: return SEL_COUNT;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/wt_regs.sv
module wt_regs
    import wt_pkg::*;
#(
    parameter int DATA_W = WT_DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [WT_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [DATA_W-1:0]    count,
    output logic [DATA_W-1:0]    rdata,
    output logic [DATA_W-1:0]    load_val,
    output wt_cmd_t              cmd
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] load_q;
    logic              res_q;

    assign sel = decode_ofs(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '0;
            res_q  <= 1'b0;
        end else if (wr_en) begin
            if (sel == SEL_LOAD) load_q <= wdata;
            if (sel == SEL_CTRL) res_q  <= wdata[0];
        end
    end

    always_comb begin
        cmd.load       = wr_en && (sel == SEL_LOAD);
        cmd.res_change = wr_en && (sel == SEL_CTRL) && (wdata[0] != res_q);
        cmd.res        = res_q;
        load_val       = wdata;
    end

    always_comb begin
        case (sel)
            SEL_LOAD:  rdata = load_q;
            SEL_CTRL:  rdata = {{(DATA_W-1){1'b0}}, res_q};
            SEL_COUNT: rdata = count;
            default:   rdata = '0;
        endcase
    end

    // R2: the load register holds what was written to it
    a_r2_load_readback: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> (load_q == $past(wdata)));
endmodule

// File: rtl/wt_tick_div.sv
module wt_tick_div #(
    parameter int DIV_LOG = wt_pkg::WT_DIV_LOG
) (
    input  logic clk,
    input  logic rst,
    input  logic lf_tick,
    input  logic coarse,
    input  logic clr,
    output logic tick
);
    logic [DIV_LOG-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || clr) div_q <= '0;
        else if (lf_tick) div_q <= div_q + 1'b1;
    end

    assign tick = coarse ? (lf_tick && (&div_q)) : lf_tick;

    // R10: phase advances only on a reference pulse or restarts on clear
    a_r10_phase_hold: assert property (@(posedge clk) disable iff (rst)
        (!lf_tick && !clr) |=> $stable(div_q));
    // R10: a clear always leaves the phase at zero
    a_r10_phase_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (div_q == '0));
endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
    parameter int DATA_W = wt_pkg::WT_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              tick,
    output logic [DATA_W-1:0] count,
    output logic              evt
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            evt   <= 1'b0;
        end else if (load) begin
            count <= load_val;
            evt   <= 1'b0;
        end else if (tick && (count != '0)) begin
            count <= count - ONE;
            evt   <= (count == ONE);
        end else begin
            evt   <= 1'b0;
        end
    end

    // R6: the event only accompanies a count of zero
    a_r6_evt_at_zero: assert property (@(posedge clk) disable iff (rst)
        evt |-> (count == '0));
    // R6: the event never lasts two cycles
    a_r6_evt_single: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt);
    // R7: idle stays idle until a load
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        ((count == '0) && !load) |=> ((count == '0) && !evt));
    // R4: without a load the count moves by at most one step down
    a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
        (!load && (count != '0)) |=>
            ((count == $past(count)) || (count == $past(count) - ONE)));
    // R8: a load always wins
    a_r8_load_wins: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(load_val)));
endmodule

// File: rtl/wake_timer.sv
module wake_timer
    import wt_pkg::*;
#(
    parameter int DATA_W  = WT_DATA_W,
    parameter int DIV_LOG = WT_DIV_LOG
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lf_tick_i,
    input  logic                 wr_en_i,
    input  logic [WT_ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 wake_evt_o
);
    wt_cmd_t           cmd;
    logic [DATA_W-1:0] load_val;
    logic [DATA_W-1:0] count;
    logic              tick;

    wt_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en_i),
        .addr     (addr_i),
        .wdata    (wdata_i),
        .count    (count),
        .rdata    (rdata_o),
        .load_val (load_val),
        .cmd      (cmd)
    );

    wt_tick_div #(.DIV_LOG(DIV_LOG)) u_div (
        .clk     (clk),
        .rst     (rst),
        .lf_tick (lf_tick_i),
        .coarse  (cmd.res),
        .clr     (cmd.load | cmd.res_change),
        .tick    (tick)
    );

    wt_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cmd.load),
        .load_val (load_val),
        .tick     (tick),
        .count    (count),
        .evt      (wake_evt_o)
    );
endmodule

// File: tb/wake_timer_tb.sv
module wake_timer_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        lf_tick;
    logic        wr_en;
    logic [3:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        evt;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 0;

    // model state
    logic [15:0] m_pre, m_cnt;
    logic        m_res, m_evt;
    logic [11:0] m_div;

    always #2 clk = ~clk;

    wake_timer u_dut (
        .clk        (clk),
        .rst        (rst),
        .lf_tick_i  (lf_tick),
        .wr_en_i    (wr_en),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .wake_evt_o (evt)
    );

    function automatic logic [15:0] exp_read(input logic [3:0] a);
        case (a)
            4'h0:    return m_pre;
            4'h4:    return {15'b0, m_res};
            4'h8:    return m_cnt;
            default: return 16'h0;
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus: drive at falling edge, model the edge, check next falling edge
    task automatic step(input logic we, input logic [3:0] a, input logic [15:0] wd,
                        input logic lf, input string tag);
        logic ld, rc, tk;
        wr_en = we; addr = a; wdata = wd; lf_tick = lf;
        ld = we && (a == 4'h0);
        rc = we && (a == 4'h4) && (wd[0] != m_res);
        tk = m_res ? (lf && (m_div == 12'hFFF)) : lf;
        if (ld) begin
            m_cnt = wd; m_evt = 1'b0;
        end else if (tk && m_cnt != 0) begin
            m_evt = (m_cnt == 16'd1); m_cnt = m_cnt - 16'd1;
        end else m_evt = 1'b0;
        if (ld || rc) m_div = '0;
        else if (lf) m_div = m_div + 12'd1;
        if (ld) m_pre = wd;
        if (we && a == 4'h4) m_res = wd[0];
        @(posedge clk);
        @(negedge clk);
        chk(evt == m_evt, {tag, " event"}, {15'b0, evt}, {15'b0, m_evt});
        chk(rdata == exp_read(a), {tag, " read"}, rdata, exp_read(a));
        wr_en = 1'b0; lf_tick = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        step(1'b0, a, 16'h0, 1'b0, tag);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; lf_tick = 0; wr_en = 0; addr = 0; wdata = 0;
        m_pre = 0; m_cnt = 0; m_res = 0; m_evt = 0; m_div = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        rd(4'h0, "R1 load");
        rd(4'h4, "R1 ctrl");
        rd(4'h8, "R1 count");
        chk(rdata == 16'h0, "R1 literal", rdata, 16'h0);

        // R2 load and start
        step(1, 4'h0, 16'd5, 0, "R2 write");
        rd(4'h8, "R2 count");
        chk(rdata == 16'd5, "R2 literal", rdata, 16'd5);
        // R4 fine ticks with gaps, R6 event on last
        for (int i = 0; i < 5; i++) begin
            step(0, 4'h8, 0, 1, "R4 tick");
            if (i == 4) chk(evt == 1'b1, "R6 expiry", {15'b0, evt}, 16'd1);
            rd(4'h8, "R4 gap");
        end
        chk(evt == 1'b0, "R6 one cycle", {15'b0, evt}, 16'd0);
        // R7 idle
        repeat (4) step(0, 4'h8, 0, 1, "R7 idle");
        // R8 load with simultaneous tick
        step(1, 4'h0, 16'd3, 1, "R8 load+tick");
        rd(4'h8, "R8 count");
        chk(rdata == 16'd3, "R8 literal", rdata, 16'd3);
        // R9 write to count ignored
        step(1, 4'h8, 16'h00AA, 0, "R9 write count");
        chk(rdata == 16'd3, "R9 literal", rdata, 16'd3);
        // R3 stop by zero
        step(1, 4'h0, 16'd0, 0, "R3 stop");
        repeat (3) step(0, 4'h8, 0, 1, "R3 stopped");
        // R11 ctrl masking and unmapped offset
        step(1, 4'h4, 16'hFFFE, 0, "R11 ctrl");
        step(1, 4'hC, 16'h1234, 0, "R11 unmapped");
        rd(4'h4, "R11 ctrl read");
        // R5 coarse: preload 2, reference every cycle
        step(1, 4'h4, 16'h0001, 0, "R5 coarse");
        step(1, 4'h0, 16'd2, 0, "R5 load");
        for (int i = 0; i < 8200; i++) step(0, 4'h8, 0, 1, "R5 run");
        // R10 same-value write keeps phase, change restarts phase
        step(1, 4'h0, 16'd2, 0, "R10 load");
        for (int i = 0; i < 2000; i++) step(0, 4'h8, 0, 1, "R10 run");
        step(1, 4'h4, 16'h0001, 1, "R10 same res");
        for (int i = 0; i < 2200; i++) step(0, 4'h8, 0, 1, "R10 keep");
        step(1, 4'h4, 16'h0000, 0, "R10 to fine");
        step(1, 4'h4, 16'h0001, 0, "R10 to coarse");
        for (int i = 0; i < 4200; i++) step(0, 4'h8, 0, 1, "R10 restart");
        step(1, 4'h4, 16'h0000, 0, "R4 back fine");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] a;
            logic we;
            a = 4'($urandom_range(0, 3) * 4);
            we = ($urandom_range(0, 9) == 0);
            step(we, a, 16'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), "R6 random");
        end
        finish_run();
    end
endmodule